// File: doc/BRIEF.md
# Serial Register Control Slave

This block is the slave end of a serial control port. A host shifts 24-bit control words into it, one bit per rising edge of the serial clock, and uses a separate latch line to mark where a word ends. Each word is a direction flag, a 7-bit register address and a 16-bit payload. A write lands in a bank of 16-bit registers when the latch line rises. A read returns the addressed register 16 bits at a time, MSB first, either on the shared bidirectional data line or on a dedicated output pin.

Two bits of one configuration register choose the read return path and the way the driver behaves. On the shared line the driver can push both levels or work as open-drain. On the dedicated pin it can push both levels or work as wired-OR. Each pad is modelled as a value plus an output-enable. The serial pins are sampled in a fast system clock domain, so every serial edge is handled as a one-cycle event.

Top module: `serial_ctrl_slave`

## Requirements
- R1: Word bits arrive in this order: direction flag (1 = read, 0 = write), then address bits 6 down to 0, then payload bits 15 down to 0. Each rising edge of `ser_clk` captures `ser_din`. A pin edge is acted on at the second rising `clk` edge after the pin changes.
- R2: A rising edge of `ser_latch` commits the last 24 captured bits as one word. Bits captured before those 24 have no effect. A word with the direction flag at 0 writes its payload to its address.
- R3: Registers 0 to 31 exist and all except the configuration register reset to 0. Writes to addresses 32 to 127 change nothing, and reads of those addresses return 0.
- R4: The configuration register is at address 0x16 and resets to 0x8000. Bit 15 selects the return path (1 = shared line, 0 = dedicated pin). Bit 14 selects the driver style (0 = push both levels).
- R5: In a read, the first payload bit (bit 15) appears on the falling `ser_clk` edge after the eighth captured bit. Each later falling edge moves to the next lower bit. The falling edge after bit 0 ends the data phase.
- R6: With bit 15 = 0, read data comes out on `ser_dout_o`/`ser_dout_oe`, `ser_dio_oe` stays 0, and `ser_din` during the data phase does not alter the returned value.
- R7: Shared-line push style (0x8000): during the data phase `ser_dio_oe` is 1 and `ser_dio_o` carries the bit. At all other times `ser_dio_oe` is 0.
- R8: Shared-line open-drain style (0xC000): `ser_dio_o` is always 0. During the data phase `ser_dio_oe` is 1 exactly when the bit is 0.
- R9: Dedicated-pin push style (0x0000): `ser_dout_oe` is always 1, and `ser_dout_o` is the data bit during the data phase and 0 otherwise.
- R10: Dedicated-pin wired-OR style (0x4000): `ser_dout_o` is 0, and `ser_dout_oe` is 1 only for a 0 bit during the data phase, so the pin is released when idle.
- R11: A `ser_latch` rise ends any read in progress and restarts the bit count. If a `ser_clk` rise is seen in the same cycle, that bit is part of the committed word.
- R12: `rst_n` is a synchronous active-low reset. After reset all four pad outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_latch | input | 1 | Framing line; its rising edge commits a word |
| ser_din | input | 1 | Serial data from the host |
| ser_dio_o | output | 1 | Shared-line drive value |
| ser_dio_oe | output | 1 | Shared-line output-enable |
| ser_dout_o | output | 1 | Dedicated read pin drive value |
| ser_dout_oe | output | 1 | Dedicated read pin output-enable |

## Verification
The latch rise and a serial clock rise can land in the same system cycle. That cycle both captures a bit and commits a word, and it must reset the bit count without losing the bit. The bench provokes this by raising both pins on the same edge for the last bit of a write. It then reads the register back, which shows whether the committed word was aligned. A second collision, a latch rise that cuts a read off part way through its data phase, is checked by sampling the enable two cycles later and reading the same register again. The cycle-by-cycle reference compares all four pad outputs on every clock throughout.

// File: rtl/scs_pkg.sv
// Shared definitions for the serial register control slave.
package scs_pkg;
    localparam int SCS_ADDR_W = 7;
    localparam int SCS_DATA_W = 16;

    // Drive variant, encoded as {shared_line_select, style_bit}
    typedef enum logic [1:0] {
        DRV_PIN_PUSH   = 2'b00,
        DRV_PIN_WOR    = 2'b01,
        DRV_LINE_PUSH  = 2'b10,
        DRV_LINE_OD    = 2'b11
    } scs_drive_e;
endpackage

// File: rtl/scs_front.sv
// Serial front end: registers the serial pins in the system clock domain,
// turns their transitions into one-cycle events, shifts captured bits into a
// word register and counts bits since the last latch rise.
// Assumes the serial pins hold each level for at least two system clocks.
module scs_front #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5,
    parameter int WORD_W = 1 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_pin,
    input  logic              latch_pin,
    input  logic              din_pin,
    output logic              sclk_rise,
    output logic              sclk_fall,
    output logic              latch_rise,
    output logic [WORD_W-1:0] word_next,
    output logic [ADDR_W:0]   hdr_q,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              sclk_s, sclk_p, latch_s, latch_p, din_s;
    logic [WORD_W-1:0] shreg_q;

    // Sample the pins and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s  <= 1'b0;
            sclk_p  <= 1'b0;
            latch_s <= 1'b1;
            latch_p <= 1'b1;
            din_s   <= 1'b0;
        end else begin
            sclk_s  <= sclk_pin;
            sclk_p  <= sclk_s;
            latch_s <= latch_pin;
            latch_p <= latch_s;
            din_s   <= din_pin;
        end
    end

    assign sclk_rise  = sclk_s & ~sclk_p;
    assign sclk_fall  = ~sclk_s & sclk_p;
    assign latch_rise = latch_s & ~latch_p;

    // Word including a bit captured in this very cycle
    assign word_next = sclk_rise ? {shreg_q[WORD_W-2:0], din_s} : shreg_q;
    assign hdr_q     = shreg_q[ADDR_W:0];

    // Shift register holding the most recent bits
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= word_next;
    end

    // Saturating count of bits since the last latch rise
    always_ff @(posedge clk) begin
        if (!rst_n)                            bit_cnt <= '0;
        else if (latch_rise)                   bit_cnt <= '0;
        else if (sclk_rise && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

    // R11
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> bit_cnt == '0);

    // R1
    shift_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> shreg_q[0] == $past(din_s));
endmodule

// File: rtl/scs_regbank.sv
// Register bank: NUM_REGS words of DATA_W bits, one of which is the
// configuration register carrying the return path and drive style bits.
// Assumes NUM_REGS <= 2**ADDR_W and CFG_ADDR < NUM_REGS.
module scs_regbank #(
    parameter int              ADDR_W    = 7,
    parameter int              DATA_W    = 16,
    parameter int              NUM_REGS  = 32,
    parameter int              CFG_ADDR  = 22,
    parameter int              MODE_BIT  = 15,
    parameter int              STYLE_BIT = 14,
    parameter logic [DATA_W-1:0] CFG_RESET = {1'b1, {(DATA_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_mode,
    output logic              cfg_style
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              wr_hit, rd_hit;

    assign wr_hit = int'(wr_addr) < NUM_REGS;
    assign rd_hit = int'(rd_addr) < NUM_REGS;

    // Register storage with per-entry reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= (i == CFG_ADDR) ? CFG_RESET : '0;
        end else if (wr_en && wr_hit) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    // Read port; absent addresses return zero
    always_comb begin
        rd_data = '0;
        if (rd_hit) rd_data = mem[rd_addr[IDX_W-1:0]];
    end

    assign cfg_mode  = mem[CFG_ADDR][MODE_BIT];
    assign cfg_style = mem[CFG_ADDR][STYLE_BIT];

    // R2
    commit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=> mem[$past(wr_addr[IDX_W-1:0])] == $past(wr_data));

    // R3
    unimpl_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> (cfg_mode == $past(cfg_mode)) && (cfg_style == $past(cfg_style)));
endmodule

// File: rtl/scs_readout.sv
// Read return path: loads the addressed register after the header bits,
// shifts it out MSB first on falling serial clock edges, and turns the
// current bit into value/enable pairs for the shared line or dedicated pin.
// Assumes a latch rise always wins over a coincident serial clock fall.
module scs_readout
    import scs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 5,
    parameter int HDR_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              latch_rise,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              hdr_rw,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cfg_mode,
    input  logic              cfg_style,
    output logic              active,
    output logic              dio_o,
    output logic              dio_oe,
    output logic              dout_o,
    output logic              dout_oe
);
    localparam int LEFT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] out_sh;
    logic [LEFT_W-1:0] left;
    logic              launch, cur_bit;
    scs_drive_e        drive;

    assign launch  = sclk_fall && (bit_cnt == CNT_W'(HDR_BITS)) && hdr_rw;
    assign cur_bit = out_sh[DATA_W-1];
    assign drive   = scs_drive_e'({cfg_mode, cfg_style});

    // Data phase sequencing: load, shift on each fall, stop after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            out_sh <= '0;
            left   <= '0;
        end else if (latch_rise) begin
            active <= 1'b0;
        end else if (sclk_fall) begin
            if (launch) begin
                active <= 1'b1;
                out_sh <= rd_data;
                left   <= LEFT_W'(DATA_W - 1);
            end else if (active) begin
                if (left == '0) begin
                    active <= 1'b0;
                end else begin
                    out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                    left   <= left - 1'b1;
                end
            end
        end
    end

    // Pad drive for the selected return path and style
    always_comb begin
        dio_o   = 1'b0;
        dio_oe  = 1'b0;
        dout_o  = 1'b0;
        dout_oe = 1'b0;
        case (drive)
            DRV_LINE_PUSH: begin
                dio_oe = active;
                dio_o  = active & cur_bit;
            end
            DRV_LINE_OD:  dio_oe = active & ~cur_bit;
            DRV_PIN_PUSH: begin
                dout_oe = 1'b1;
                dout_o  = active & cur_bit;
            end
            default:      dout_oe = active & ~cur_bit;
        endcase
    end

    // R11
    read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> !active);

    // R5
    data_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sclk_fall && !latch_rise && left != '0) |=> out_sh[DATA_W-1] == $past(out_sh[DATA_W-2]));
endmodule

// File: rtl/serial_ctrl_slave.sv
// Serial register control slave top: joins the front end, the register bank
// and the read return path. Writes commit on the latch rise; reads stream
// the addressed register back on the path chosen by the configuration bits.
// Assumes the host runs the serial clock well below clk/4.
module serial_ctrl_slave #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 32,
    parameter int CFG_ADDR  = 22,
    parameter int MODE_BIT  = 15,
    parameter int STYLE_BIT = 14,
    parameter int CNT_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_latch,
    input  logic ser_din,
    output logic ser_dio_o,
    output logic ser_dio_oe,
    output logic ser_dout_o,
    output logic ser_dout_oe
);
    localparam int WORD_W   = 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS = 1 + ADDR_W;

    logic              sclk_rise, sclk_fall, latch_rise;
    logic [WORD_W-1:0] word_next;
    logic [ADDR_W:0]   hdr_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en, cfg_mode, cfg_style, active;
    logic [DATA_W-1:0] rd_data;

    scs_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_front (
        .clk(clk), .rst_n(rst_n),
        .sclk_pin(ser_clk), .latch_pin(ser_latch), .din_pin(ser_din),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .latch_rise(latch_rise),
        .word_next(word_next), .hdr_q(hdr_q), .bit_cnt(bit_cnt)
    );

    // A word with its direction flag clear is a write
    assign wr_en = latch_rise && !word_next[WORD_W-1];

    scs_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                  .CFG_ADDR(CFG_ADDR), .MODE_BIT(MODE_BIT), .STYLE_BIT(STYLE_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(word_next[WORD_W-2 -: ADDR_W]), .wr_data(word_next[DATA_W-1:0]),
        .rd_addr(hdr_q[ADDR_W-1:0]), .rd_data(rd_data),
        .cfg_mode(cfg_mode), .cfg_style(cfg_style)
    );

    scs_readout #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HDR_BITS(HDR_BITS)) u_read (
        .clk(clk), .rst_n(rst_n),
        .sclk_fall(sclk_fall), .latch_rise(latch_rise), .bit_cnt(bit_cnt),
        .hdr_rw(hdr_q[ADDR_W]), .rd_data(rd_data),
        .cfg_mode(cfg_mode), .cfg_style(cfg_style),
        .active(active),
        .dio_o(ser_dio_o), .dio_oe(ser_dio_oe), .dout_o(ser_dout_o), .dout_oe(ser_dout_oe)
    );

    // R5
    launch_after_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(bit_cnt) == CNT_W'(HDR_BITS)) && $past(hdr_q[ADDR_W]));

    // R6
    pin_path_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_mode) |-> !ser_dio_oe);
endmodule

// File: tb/sim_serial_ctrl_slave.sv
module sim_serial_ctrl_slave;
    localparam int H = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, latch = 1'b1, din = 1'b0;
    logic dio_o, dio_oe, dout_o, dout_oe;
    int   n_run = 0, n_fail = 0;
    bit   line_mode = 1'b1;
    bit   seen_dio_oe, seen_dio_high;

    always #2.5 clk = ~clk;

    serial_ctrl_slave u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_latch(latch), .ser_din(din),
        .ser_dio_o(dio_o), .ser_dio_oe(dio_oe), .ser_dout_o(dout_o), .ser_dout_oe(dout_oe)
    );

    // Behavioural reference model, advanced on every clock
    int m_regs [128];
    int m_word, m_cnt, m_dat, m_left, m_a;
    bit m_act, s1, s2, c1, c2, d1, e_rise, e_fall, e_latch;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_regs[22] = 32'h8000;
            s1 = 0; s2 = 0; c1 = 1; c2 = 1; d1 = 0;
            m_word = 0; m_cnt = 0; m_act = 0; m_dat = 0; m_left = 0;
        end else begin
            e_rise = s1 && !s2; e_fall = !s1 && s2; e_latch = c1 && !c2;
            if (e_rise) begin
                m_word = ((m_word << 1) | int'(d1)) & 32'hFFFFFF;
                if (m_cnt < 31) m_cnt++;
            end
            if (e_latch) begin
                if (m_word[23] == 1'b0) begin
                    m_a = (m_word >> 16) & 127;
                    if (m_a < 32) m_regs[m_a] = m_word & 32'hFFFF;
                end
                m_cnt = 0; m_act = 0;
            end else if (e_fall) begin
                if (m_cnt == 8 && m_word[7]) begin
                    m_a = m_word & 127;
                    m_dat = (m_a < 32) ? m_regs[m_a] : 0;
                    m_act = 1; m_left = 15;
                end else if (m_act) begin
                    if (m_left == 0) m_act = 0;
                    else m_left--;
                end
            end
            s2 = s1; s1 = sclk; c2 = c1; c1 = latch; d1 = din;
        end
    end

    // Compare all pads against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit mode, sty, b;
            logic [1:0] e_dio, e_dout;
            mode = m_regs[22][15]; sty = m_regs[22][14];
            b = m_act && m_dat[m_left];
            e_dio = 2'b00; e_dout = 2'b00;
            if (mode) e_dio = sty ? {1'b0, m_act && !b} : {b, m_act};
            else      e_dout = sty ? {1'b0, m_act && !b} : {b, 1'b1};
            n_run++;
            if ({dio_o, dio_oe} !== e_dio || {dout_o, dout_oe} !== e_dout) begin
                n_fail++;
                $display("FAIL R5 R6 R7 R8 R9 R10 pads at %0t: actual dio=%b%b dout=%b%b expected dio=%b%b dout=%b%b",
                         $time, dio_o, dio_oe, dout_o, dout_oe, e_dio[1], e_dio[0], e_dout[1], e_dout[0]);
            end
            if (dio_oe) seen_dio_oe = 1;
            if (dio_o)  seen_dio_high = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit level();
        if (line_mode) return dio_oe ? dio_o : 1'b1;
        return dout_oe ? dout_o : 1'b1;
    endfunction

    task automatic shift_bit(input bit b, output bit seen);
        sclk = 0; din = b; idle(H);
        seen = level();
        sclk = 1; idle(H);
    endtask

    task automatic xfer(input bit rw, input int addr, input int data, input int pre,
                        input bit join_last, output logic [15:0] got);
        logic [23:0] w;
        bit seen;
        w = {rw, 7'(addr), 16'(data)};
        got = '0;
        latch = 0; idle(H);
        for (int k = 0; k < pre; k++) shift_bit(1'b0, seen);
        for (int i = 23; i >= 0; i--) begin
            if (join_last && i == 0) begin
                sclk = 0; din = w[0]; idle(H);
                got[0] = level();
                sclk = 1; latch = 1; idle(H);
                sclk = 0; idle(2*H);
            end else begin
                shift_bit(w[i], seen);
                if (i < 16) got[i] = seen;
            end
        end
        if (!join_last) begin
            sclk = 0; idle(H); latch = 1; idle(2*H);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [15:0] got;
        bit seen;
        idle(4);
        // R12: pads low out of reset
        check({dio_o, dio_oe, dout_o, dout_oe} == 4'b0000, "R12 reset pads",
              {dio_o, dio_oe, dout_o, dout_oe}, 0);
        rst_n = 1; idle(4);
        check({dio_o, dio_oe, dout_o, dout_oe} == 4'b0000, "R12 idle after reset",
              {dio_o, dio_oe, dout_o, dout_oe}, 0);

        // R4: configuration reset value
        xfer(1, 22, 16'h3C3C, 0, 0, got);
        check(got == 16'h8000, "R4 config reset", got, 16'h8000);
        // R3: ordinary register resets to 0
        xfer(1, 5, 16'hFFFF, 0, 0, got);
        check(got == 16'h0000, "R3 reset zero", got, 0);

        // R1 R7: write then read on the shared line, push style
        xfer(0, 3, 16'hA5C3, 0, 0, got);
        xfer(1, 3, 16'h0000, 0, 0, got);
        check(got == 16'hA5C3, "R1 R7 shared push read", got, 16'hA5C3);

        // R2: six extra leading bits are discarded
        xfer(0, 4, 16'h1234, 6, 0, got);
        xfer(1, 4, 16'hFFFF, 0, 0, got);
        check(got == 16'h1234, "R2 last 24 bits", got, 16'h1234);

        // R3: write to absent address is dropped and reads 0, no alias at 16
        xfer(0, 7'h50, 16'hBEEF, 0, 0, got);
        xfer(1, 7'h50, 16'h0000, 0, 0, got);
        check(got == 16'h0000, "R3 absent read", got, 0);
        xfer(1, 16, 16'h0000, 0, 0, got);
        check(got == 16'h0000, "R3 no alias", got, 0);

        // R11: latch rise cuts a read short
        latch = 0; idle(H);
        for (int i = 23; i >= 11; i--) shift_bit((i == 23) ? 1'b1 : ((i < 16) ? 1'b0 : ((7'd3 >> (i - 16)) & 1'b1)), seen);
        sclk = 0; idle(H);
        check(dio_oe == 1'b1, "R5 data phase enabled", dio_oe, 1);
        latch = 1; idle(2);
        check(dio_oe == 1'b0, "R11 read abort", dio_oe, 0);
        idle(2*H);
        xfer(1, 3, 16'h0000, 0, 0, got);
        check(got == 16'hA5C3, "R11 read after abort", got, 16'hA5C3);

        // R11: latch and serial clock rise together on the final bit
        xfer(0, 7, 16'h0F0F, 0, 1, got);
        xfer(1, 7, 16'h0000, 0, 0, got);
        check(got == 16'h0F0F, "R11 coincident edges", got, 16'h0F0F);

        // R8: shared line open-drain
        xfer(0, 22, 16'hC000, 0, 0, got);
        seen_dio_high = 0;
        xfer(1, 3, 16'h0000, 0, 0, got);
        check(got == 16'hA5C3, "R8 open-drain read", got, 16'hA5C3);
        check(!seen_dio_high, "R8 never drives high", seen_dio_high, 0);

        // R9 R6: dedicated pin push style, data input toggled in data phase
        xfer(0, 22, 16'h0000, 0, 0, got);
        line_mode = 0;
        check(dout_oe == 1'b1 && dout_o == 1'b0, "R9 idle driven low", {dout_o, dout_oe}, 2'b01);
        seen_dio_oe = 0;
        xfer(1, 4, 16'hAAAA, 0, 0, got);
        check(got == 16'h1234, "R6 pin read ignores input", got, 16'h1234);
        check(!seen_dio_oe, "R6 shared line quiet", seen_dio_oe, 0);

        // R10: dedicated pin wired-OR
        xfer(0, 22, 16'h4000, 0, 0, got);
        check(dout_oe == 1'b0, "R10 idle released", dout_oe, 0);
        xfer(1, 3, 16'h5555, 0, 0, got);
        check(got == 16'hA5C3, "R10 wired-OR read", got, 16'hA5C3);

        // R4: back to the shared line
        xfer(0, 22, 16'h8000, 0, 0, got);
        line_mode = 1;
        check(dout_oe == 1'b0, "R4 pin released in line mode", dout_oe, 0);
        xfer(1, 7, 16'h0000, 0, 0, got);
        check(got == 16'h0F0F, "R4 R7 line read", got, 16'h0F0F);

        idle(10);
        summary();
    end
endmodule